// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request port to an external asynchronous static RAM that holds 32K bytes. A requester presents a write flag, a 15-bit address and a write byte with `req_valid`. The block takes the request only while it is idle and signals this with `req_ready`. It then runs one complete read or write cycle on the memory pins. Read data comes back on `rsp_data` together with a one-cycle `rsp_valid` strobe.

The memory side has active-low chip select, write enable and output enable, and an address bus. The data path is split so that an external tristate pad can be attached: `mem_dout` carries data to the memory, `mem_din` carries data from it, and `mem_dq_oe` enables the pad driver.

The memory's minimum timings are parameters in nanoseconds. At elaboration each one is converted to whole clock cycles, rounded up, and each must amount to at least one cycle. One shared down-counter times every phase and is reloaded whenever a phase begins. Between requests the chip select stays high, which keeps the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and directly after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only in the idle state, where `mem_cs_n` is high. A request is taken on a clock edge with `req_valid` and `req_ready` both high, and `req_ready` is low in the following cycle.
- R3: A read holds `mem_cs_n` and `mem_oe_n` low, `mem_we_n` high and the address steady for the read window. The window is the ceiling of the largest of read cycle time, address access time and output-enable access time, divided by the clock period (14 cycles with the defaults). `mem_din` is captured at the edge that closes the window. The captured byte appears on `rsp_data` with `rsp_valid` high for exactly one cycle.
- R4: A write first spends one setup cycle with `mem_cs_n` low and `mem_we_n` high. `mem_we_n` is then low for the pulse length: the ceiling in cycles of the largest of write pulse width, data setup time, and write cycle time minus two cycles (12 cycles with the defaults). One hold cycle follows with `mem_we_n` high and `mem_cs_n` still low, after which `mem_cs_n` returns high.
- R5: `mem_oe_n` stays high for the whole write, including every cycle in which `mem_we_n` is low or `mem_dq_oe` is high.
- R6: While `mem_cs_n` is low on two consecutive cycles, `mem_addr` does not change. The address therefore never changes on the same edge as a write-enable transition.
- R7: `mem_dq_oe` is high exactly during the write-enable-low cycles and the one hold cycle after them, and it is low at all other times. While it is high, `mem_dout` carries the byte that was accepted with the request.
- R8: After a read window ends, `mem_cs_n` and `mem_oe_n` are high and `req_ready` stays low for the turnaround length before the next request can be taken. The turnaround length is the ceiling in cycles of the memory's output release time (6 cycles with the defaults).
- R9: A read returns the byte most recently written to that address, or 0x00 if the address was never written, under any mix of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_data | output | 8 | Read byte |
| rsp_valid | output | 1 | One-cycle strobe for rsp_data |
| mem_addr | output | 15 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dout | output | 8 | Data toward the memory |
| mem_din | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Enable of the external data pad driver |

## Verification
The two functions most likely to collide are the release of the data bus after a read and the start of the driver for a following write. A write issued directly behind a read could turn on `mem_dq_oe` while the memory is still driving its pins. The bench provokes this with directed read-then-write pairs and with random mixes of reads and writes. A bus model tracks how long the memory keeps driving after output enable rises, and flags any overlap as contention. The model also returns the inverse of the stored byte until the full access time has passed, so capturing the read data one edge early shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_RD_TURN,
        PH_WR_SET,
        PH_WR_PULSE,
        PH_WR_HOLD
    } phase_e;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              valid_d, valid_q;

    always_comb begin
        data_d  = take ? din : data_q;
        valid_d = take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 5,
    parameter int T_RC_NS    = 70,
    parameter int T_AA_NS    = 70,
    parameter int T_OE_NS    = 35,
    parameter int T_WC_NS    = 70,
    parameter int T_WP_NS    = 50,
    parameter int T_DW_NS    = 30,
    parameter int T_REL_NS   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dq_oe
);
    localparam int RC_C   = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int AA_C   = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int OE_C   = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int WC_C   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int WP_C   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int DW_C   = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int TURN_C = ns_to_cyc(T_REL_NS, CLK_NS);
    // read window covers every applicable access time
    localparam int RD_CYC    = max3(RC_C, AA_C, OE_C);
    // setup and hold cycles count toward the write cycle time
    localparam int PULSE_CYC = max3(WP_C, DW_C, WC_C - 2);
    localparam int MAX_CYC   = max3(RD_CYC, PULSE_CYC, TURN_C);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    if (CLK_NS < 1) begin : g_bad_clk
        $error("clock period must be positive");
    end
    if (RC_C < 1 || AA_C < 1 || OE_C < 1) begin : g_bad_rd
        $error("read timings must span at least one cycle");
    end
    if (WC_C < 1 || WP_C < 1 || DW_C < 1) begin : g_bad_wr
        $error("write timings must span at least one cycle");
    end
    if (TURN_C < 1) begin : g_bad_turn
        $error("release time must span at least one cycle");
    end

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
    } ctrl_t;

    ctrl_t             c_d, c_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              cap_take;

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_take = 1'b0;
        case (c_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    c_d.cs_n  = 1'b0;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        c_d.ph  = PH_WR_SET;
                    end else begin
                        c_d.ph   = PH_RD_ACC;
                        c_d.oe_n = 1'b0;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_RD_ACC: begin
                if (tmr_done) begin
                    cap_take = 1'b1;
                    c_d.ph   = PH_RD_TURN;
                    c_d.cs_n = 1'b1;
                    c_d.oe_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_C - 1);
                end
            end
            PH_RD_TURN: begin
                if (tmr_done) begin
                    c_d.ph   = PH_IDLE;
                    tmr_load = 1'b1;
                end
            end
            PH_WR_SET: begin
                if (tmr_done) begin
                    c_d.ph   = PH_WR_PULSE;
                    c_d.we_n = 1'b0;
                    c_d.drv  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PULSE_CYC - 1);
                end
            end
            PH_WR_PULSE: begin
                if (tmr_done) begin
                    c_d.ph   = PH_WR_HOLD;
                    c_d.we_n = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            PH_WR_HOLD: begin
                if (tmr_done) begin
                    c_d.ph   = PH_IDLE;
                    c_d.cs_n = 1'b1;
                    c_d.drv  = 1'b0;
                    tmr_load = 1'b1;
                end
            end
            default: begin
                c_d.ph   = PH_IDLE;
                c_d.cs_n = 1'b1;
                c_d.we_n = 1'b1;
                c_d.oe_n = 1'b1;
                c_d.drv  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{ph: PH_IDLE, addr: '0, wdata: '0,
                     cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    sram_phase_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .done  (tmr_done)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (cap_take),
        .din   (mem_din),
        .data  (rsp_data),
        .valid (rsp_valid)
    );

    assign req_ready = (c_q.ph == PH_IDLE);
    assign mem_addr  = c_q.addr;
    assign mem_cs_n  = c_q.cs_n;
    assign mem_we_n  = c_q.we_n;
    assign mem_oe_n  = c_q.oe_n;
    assign mem_dout  = c_q.wdata;
    assign mem_dq_oe = c_q.drv;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int ADDR_W   = 15,
    parameter int TURN_CYC = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    // cycles since output enable was last low, saturating
    logic [7:0] since_oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_oe_q <= 8'hFF;
        else if (!mem_oe_n)
            since_oe_q <= 8'h00;
        else if (since_oe_q != 8'hFF)
            since_oe_q <= since_oe_q + 8'd1;
    end

    a_r2_ready_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

    a_r3_we_high_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n));

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    a_r4_cs_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    a_r7_drive_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    a_r7_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_cs_n);

    a_r8_turnaround_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(since_oe_q) >= TURN_CYC));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .TURN_CYC (TURN_C)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    localparam int ACC_CYC   = 14;  // R3 default read window
    localparam int PULSE_CYC = 12;  // R4 default pulse
    localparam int TURN_CYC  = 6;   // R8 default turnaround
    localparam int WP_MIN    = 10;
    localparam int DW_MIN    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_data;
    logic        rsp_valid;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = 8'h00;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    logic [7:0] model_mem [int];
    logic [7:0] ref_mem   [int];

    always #2.5 clk = ~clk;

    sram_async_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_read(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    // behavioural memory and bus monitor, evaluated mid-cycle
    logic [14:0] prev_addr = '0;
    bit  prev_wr = 0, prev_rd = 0;
    int  wr_len = 0, dstable = 0, rd_cnt = 0, relax = 0;
    logic [7:0] last_dout = '0;

    always @(negedge clk) begin
        bit wr_on, rd_on;
        logic [7:0] v;
        if (rst_n) begin
            wr_on = !mem_cs_n && !mem_we_n;
            rd_on = !mem_cs_n && !mem_oe_n && mem_we_n;
            if (wr_on) begin
                if (prev_wr && mem_addr != prev_addr)
                    chk(0, "R6 address moved in write", int'(mem_addr), int'(prev_addr));
                if (!mem_dq_oe || !mem_oe_n)
                    chk(0, "R7 data not driven in write", int'(mem_dq_oe), 1);
                if (prev_wr && mem_dout == last_dout) dstable++;
                else dstable = 1;
                wr_len = prev_wr ? wr_len + 1 : 1;
                last_dout = mem_dout;
            end else if (prev_wr) begin
                if (wr_len < WP_MIN)
                    chk(0, "R4 write pulse short", wr_len, WP_MIN);
                if (dstable < DW_MIN)
                    chk(0, "R4 data setup short", dstable, DW_MIN);
                model_mem[int'(prev_addr)] = last_dout;
            end
            if (mem_dq_oe && (rd_on || relax > 0))
                chk(0, "R8 bus contention", relax, 0);
            if (rd_on) begin
                rd_cnt = (prev_rd && mem_addr == prev_addr) ? rd_cnt + 1 : 1;
                v = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
                mem_din = (rd_cnt >= ACC_CYC) ? v : ~v;
                relax = TURN_CYC;
            end else if (relax > 0) begin
                relax--;
            end
            prev_wr = wr_on;
            prev_rd = rd_on;
            prev_addr = mem_addr;
        end
    end

    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int guard = 0;
        while (!req_ready && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready drops after accept", int'(req_ready), 0);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        int n = 0;
        bit ok_oe = 1, ok_drv = 1, ok_addr = 1;
        issue(1'b1, a, d);
        chk(!mem_cs_n && mem_we_n && !mem_dq_oe && mem_oe_n, "R4 setup cycle",
            {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b010);
        @(negedge clk);
        while (!mem_we_n && n < 100) begin
            n++;
            if (!mem_oe_n) ok_oe = 0;
            if (!mem_dq_oe || mem_dout != d) ok_drv = 0;
            if (mem_addr != a || mem_cs_n) ok_addr = 0;
            @(negedge clk);
        end
        chk(n == PULSE_CYC, "R4 write pulse length", n, PULSE_CYC);
        chk(ok_oe, "R5 output enable high in write", 0, 1);
        chk(ok_drv, "R7 driven byte during pulse", int'(mem_dout), int'(d));
        chk(ok_addr, "R6 address held in write", int'(mem_addr), int'(a));
        chk(!mem_cs_n && mem_we_n && mem_dq_oe && mem_oe_n && mem_addr == a,
            "R7 hold cycle", {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b011);
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe && req_ready, "R2 idle after write",
            {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);
        ref_mem[int'(a)] = d;
    endtask

    task automatic do_read(input logic [14:0] a);
        int n = 0;
        bit ok_pins = 1;
        logic [7:0] e;
        e = ref_read(int'(a));
        issue(1'b0, a, 8'h00);
        while (!mem_oe_n && n < 100) begin
            n++;
            if (!mem_we_n || mem_cs_n || mem_addr != a || mem_dq_oe) ok_pins = 0;
            @(negedge clk);
        end
        chk(n == ACC_CYC, "R3 read window length", n, ACC_CYC);
        chk(ok_pins, "R3 read pin levels", 0, 1);
        chk(rsp_valid == 1'b1, "R3 read strobe", int'(rsp_valid), 1);
        chk(rsp_data == e, "R9 read data", int'(rsp_data), int'(e));
        chk(mem_cs_n && mem_oe_n, "R8 deselect after read", {mem_cs_n, mem_oe_n}, 2'b11);
        n = 0;
        while (!req_ready && n < 100) begin
            n++;
            @(negedge clk);
            if (n == 1) chk(!rsp_valid, "R3 strobe one cycle", int'(rsp_valid), 0);
            if (!mem_cs_n || !mem_oe_n || mem_dq_oe)
                chk(0, "R8 bus quiet in turnaround", {mem_cs_n, mem_oe_n}, 2'b11);
        end
        chk(n == TURN_CYC, "R8 turnaround length", n, TURN_CYC);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 pins in reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe, "R2 standby when idle", {mem_cs_n, mem_dq_oe}, 2'b10);

        // directed corners
        do_write(15'h0000, 8'h3C);
        do_write(15'h7FFF, 8'hC3);
        do_read(15'h0000);
        do_read(15'h7FFF);
        do_read(15'h1234);            // never written: R9 expects 0x00
        do_write(15'h0555, 8'hAA);
        do_read(15'h0555);            // write then read same address
        do_write(15'h0555, 8'h55);    // read then write: turnaround path
        do_write(15'h0555, 8'h0F);    // overwrite
        do_read(15'h0555);

        // random mix over a small address pool
        for (int i = 0; i < 250; i++) begin
            logic [14:0] a;
            a = 15'(($urandom % 40) * 811);
            if ($urandom % 2) do_write(a, 8'($urandom));
            else do_read(a);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            chk(0, "R2 watchdog expired", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule